// File: doc/BRIEF.md
# Masked Vector Store Beat Generator

This block converts a unit-stride store of 32-bit vector elements into a series of write beats on a 64-bit memory bus. Each beat carries per-byte write strobes. A single-cycle start pulse captures four things: a word-granular base address, the element count, the index of the first element to process, and a mask word with its enable flag. The same pulse captures the packed element data. The block then walks the elements from the first index upward. It only raises the strobes of elements that must be written, so memory under skipped or masked-off elements is never touched.

Element `i` sits at byte address `4*(base_word+i)`. The 32-bit lane it occupies inside a beat follows from bit 2 of that absolute address. It does not depend on how far the element is from the first processed index, which keeps stores that begin at a nonzero index correct. When the walk ends the block pulses `done`, drops `busy` and reports a resume index of zero.

Top module: `vstore_strobe_gen`

## Requirements
- R1: An element with index below `first_idx` is never written, even when its mask bit is 1.
- R2: With `mask_en`=1, an element with `first_idx` <= i < `elem_cnt` is written exactly when bit i of `mask_i` is 1. A masked-off element leaves its memory word unchanged.
- R3: Element i goes to byte address `4*(base_word+i)`. The beat address is that byte address with bits [2:0] cleared. If address bit 2 is 0, the element uses `wr_data[31:0]` and `wr_strb[3:0]`=4'hF; otherwise it uses `wr_data[63:32]` and `wr_strb[7:4]`=4'hF. A lane that holds no written element has strobe nibble 4'h0.
- R4: No beat is presented with `wr_strb` equal to zero. The number of beats equals the number of distinct 8-byte words that hold a written element.
- R5: A beat moves on only in a cycle where `wr_valid` and `wr_ready` are both 1. While `wr_valid`=1 and `wr_ready`=0, the address, data and strobes hold steady.
- R6: At the end of a store, `done` is high for one cycle and `resume_idx` reads 0 from that cycle onward.
- R7: If `first_idx` >= `elem_cnt`, no beat is issued and `done` is high in the cycle right after the start pulse.
- R8: `busy` is high from the cycle after an accepted start until the cycle `done` rises. A start pulse while `busy` is high has no effect on the beats or on memory.
- R9: Beats are issued in strictly ascending address order.
- R10: With `mask_en`=0, every element from `first_idx` to `elem_cnt`-1 is written, whatever `mask_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a store |
| base_word | input | ADDR_W-2 | Base address in 32-bit word units |
| elem_cnt | input | CNT_W | Vector length in elements |
| first_idx | input | CNT_W | Index of the first element to process |
| mask_en | input | 1 | 1 = apply `mask_i`, 0 = write all processed elements |
| mask_i | input | MAX_VL | Bit i is the mask bit of element i |
| data_i | input | 32*MAX_VL | Element i in bits [32i+31:32i] |
| busy | output | 1 | A store is in progress |
| done | output | 1 | One-cycle completion pulse |
| resume_idx | output | CNT_W | Current element index, zero when idle after a store |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | 8-byte aligned beat byte address |
| wr_data | output | 64 | Beat data |
| wr_strb | output | 8 | Per-byte write enables |

## Verification
A lane chosen from the element's offset rather than its absolute address puts data into the wrong 4-byte half of a beat. The shadow memory then shows it at the first misaligned base or nonzero first index. A corrupted element index or mask copy leads to a word that is wrongly written or wrongly kept, or to a beat count that differs from the count of distinct active 8-byte words. All of these are visible once the store completes. Holding faults in the handshake appear in the first stalled cycle, when the beat changes while ready is low. A done or resume index that is missing or late shows up one cycle after the last beat.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int ELEM_BITS = 32;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_SEND} vsg_state_t;
endpackage

// File: rtl/vsg_lane.sv
// One 32-bit lane of a beat: which element lands here, and is it written.
module vsg_lane #(
  parameter int LANE   = 0,
  parameter int MAX_VL = 16,
  parameter int IDX_W  = 6,
  parameter int LSEL_W = 1
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic [LSEL_W-1:0]    lane0,
  input  logic [IDX_W-1:0]     vl,
  input  logic                 mask_en,
  input  logic [MAX_VL-1:0]    mask,
  input  logic [MAX_VL*32-1:0] data,
  output logic                 act,
  output logic [31:0]          word
);
  localparam int SEL_W = $clog2(MAX_VL);

  logic [IDX_W-1:0] j;
  logic [SEL_W-1:0] jj;
  logic             in_pos;

  always_comb begin
    in_pos = (LSEL_W'(LANE) >= lane0);
    j      = idx + IDX_W'(LANE) - IDX_W'(lane0);
    jj     = j[SEL_W-1:0];
    act    = in_pos && (j < vl) && (!mask_en || mask[jj]);
    word   = data[{jj, 5'b0} +: 32];
  end
endmodule

// File: rtl/vsg_beat_build.sv
// Forms the next beat starting at element idx, placed by absolute address.
module vsg_beat_build #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 16,
  parameter int BUS_W  = 64,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-3:0]    base_word,
  input  logic [IDX_W-1:0]     idx,
  input  logic [IDX_W-1:0]     vl,
  input  logic                 mask_en,
  input  logic [MAX_VL-1:0]    mask,
  input  logic [MAX_VL*32-1:0] data,
  output logic [ADDR_W-1:0]    beat_addr,
  output logic [BUS_W-1:0]     beat_data,
  output logic [BUS_W/8-1:0]   beat_strb,
  output logic [IDX_W-1:0]     next_idx
);
  localparam int LANES   = BUS_W / 32;
  localparam int LSEL_W  = $clog2(LANES);
  localparam int WADDR_W = ADDR_W - 2;

  logic [WADDR_W-1:0] wa;
  logic [LSEL_W-1:0]  lane0;

  always_comb begin
    wa        = base_word + WADDR_W'(idx);
    lane0     = wa[LSEL_W-1:0];
    beat_addr = {wa[WADDR_W-1:LSEL_W], (LSEL_W + 2)'(0)};
    next_idx  = idx + IDX_W'(LANES) - IDX_W'(lane0);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic        act;
    logic [31:0] word;
    vsg_lane #(
      .LANE(g), .MAX_VL(MAX_VL), .IDX_W(IDX_W), .LSEL_W(LSEL_W)
    ) u_lane (
      .idx(idx), .lane0(lane0), .vl(vl), .mask_en(mask_en),
      .mask(mask), .data(data), .act(act), .word(word)
    );
    assign beat_strb[4*g +: 4]  = {4{act}};
    assign beat_data[32*g +: 32] = act ? word : 32'h0;
  end
endmodule

// File: rtl/vstore_strobe_gen.sv
module vstore_strobe_gen #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 16,
  parameter int BUS_W  = 64,
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W-3:0]    base_word,
  input  logic [CNT_W-1:0]     elem_cnt,
  input  logic [CNT_W-1:0]     first_idx,
  input  logic                 mask_en,
  input  logic [MAX_VL-1:0]    mask_i,
  input  logic [MAX_VL*32-1:0] data_i,
  output logic                 busy,
  output logic                 done,
  output logic [CNT_W-1:0]     resume_idx,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [BUS_W-1:0]     wr_data,
  output logic [BUS_W/8-1:0]   wr_strb
);
  import vsg_pkg::*;

  localparam int IDX_W  = CNT_W + 1;
  localparam int STRB_W = BUS_W / 8;

  vsg_state_t           state;
  logic [ADDR_W-3:0]    base_r;
  logic [IDX_W-1:0]     vl_r;
  logic [IDX_W-1:0]     idx_r;
  logic                 men_r;
  logic [MAX_VL-1:0]    mask_r;
  logic [MAX_VL*32-1:0] data_r;

  logic [ADDR_W-1:0]    nb_addr;
  logic [BUS_W-1:0]     nb_data;
  logic [STRB_W-1:0]    nb_strb;
  logic [IDX_W-1:0]     nb_next;

  vsg_beat_build #(
    .ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .BUS_W(BUS_W), .IDX_W(IDX_W)
  ) u_build (
    .base_word(base_r), .idx(idx_r), .vl(vl_r), .mask_en(men_r),
    .mask(mask_r), .data(data_r), .beat_addr(nb_addr),
    .beat_data(nb_data), .beat_strb(nb_strb), .next_idx(nb_next)
  );

  assign resume_idx = idx_r[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      idx_r    <= '0;
      base_r   <= '0;
      vl_r     <= '0;
      men_r    <= 1'b0;
      mask_r   <= '0;
      data_r   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_strb  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (first_idx >= elem_cnt) begin
              done  <= 1'b1;
              idx_r <= '0;
            end else begin
              base_r <= base_word;
              vl_r   <= IDX_W'(elem_cnt);
              idx_r  <= IDX_W'(first_idx);
              men_r  <= mask_en;
              mask_r <= mask_i;
              data_r <= data_i;
              busy   <= 1'b1;
              state  <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (idx_r >= vl_r) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            idx_r <= '0;
            state <= ST_IDLE;
          end else begin
            idx_r <= nb_next;
            if (nb_strb != '0) begin
              wr_valid <= 1'b1;
              wr_addr  <= nb_addr;
              wr_data  <= nb_data;
              wr_strb  <= nb_strb;
              state    <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (wr_ready) begin
            wr_valid <= 1'b0;
            state    <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64,
  parameter int CNT_W  = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic [CNT_W-1:0]   resume_idx,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [BUS_W-1:0]   wr_data,
  input logic [BUS_W/8-1:0] wr_strb
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                 $stable(wr_data) && $stable(wr_strb)))
    else $error("beat changed while stalled");

  assert_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_strb != '0))
    else $error("empty beat presented");

  assert_align_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[2:0] == 3'b000))
    else $error("beat address not 8-byte aligned");

  for (genvar g = 0; g < BUS_W / 32; g++) begin : g_nib
    assert_nibble_R3: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> (wr_strb[4*g +: 4] == 4'h0 || wr_strb[4*g +: 4] == 4'hF))
      else $error("partial element strobe");
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (resume_idx == '0 && !busy))
    else $error("done without cleared index");

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy)
    else $error("beat outside busy window");

  assert_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done)
    else $error("busy dropped without done");
endmodule

bind vstore_strobe_gen vsg_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .resume_idx(resume_idx),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_strb(wr_strb)
);

// File: tb/sim_vstore_strobe_gen.sv
module sim_vstore_strobe_gen;
  localparam int ADDR_W = 32;
  localparam int MAX_VL = 16;
  localparam int BUS_W  = 64;
  localparam int CNT_W  = $clog2(MAX_VL + 1);
  localparam int MEMB   = 256;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [ADDR_W-3:0]    base_word = '0;
  logic [CNT_W-1:0]     elem_cnt = '0;
  logic [CNT_W-1:0]     first_idx = '0;
  logic                 mask_en = 1'b0;
  logic [MAX_VL-1:0]    mask_i = '0;
  logic [MAX_VL*32-1:0] data_i = '0;
  logic                 busy, done, wr_valid;
  logic                 wr_ready = 1'b1;
  logic [CNT_W-1:0]     resume_idx;
  logic [ADDR_W-1:0]    wr_addr;
  logic [BUS_W-1:0]     wr_data;
  logic [BUS_W/8-1:0]   wr_strb;

  always #5 clk = ~clk;

  vstore_strobe_gen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .BUS_W(BUS_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_word(base_word),
    .elem_cnt(elem_cnt), .first_idx(first_idx), .mask_en(mask_en),
    .mask_i(mask_i), .data_i(data_i), .busy(busy), .done(done),
    .resume_idx(resume_idx), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0]  mem [MEMB];
  logic [7:0]  expm[MEMB];
  logic [31:0] elem[MAX_VL];
  int  beats = 0;
  int  last_addr = -1;
  bit  stall_mode = 1'b0;
  int  cyc = 0;
  bit  prev_stall = 1'b0;
  logic [ADDR_W-1:0]  h_addr;
  logic [BUS_W-1:0]   h_data;
  logic [BUS_W/8-1:0] h_strb;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory slave: ready pattern, beat capture, ordering and hold checks.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= stall_mode ? ((cyc % 3) != 2) : 1'b1;
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk(wr_valid && wr_addr == h_addr && wr_data == h_data && wr_strb == h_strb,
            "R5", "stalled beat held", longint'(wr_addr), longint'(h_addr));
      end
      prev_stall <= wr_valid && !wr_ready;
      h_addr <= wr_addr; h_data <= wr_data; h_strb <= wr_strb;
      if (wr_valid && wr_ready) begin
        beats++;
        chk(wr_strb != '0, "R4", "nonzero strobe", longint'(wr_strb), 1);
        chk(int'(wr_addr) > last_addr, "R9", "ascending beat address",
            longint'(wr_addr), longint'(last_addr));
        last_addr = int'(wr_addr);
        for (int b = 0; b < 8; b++)
          if (wr_strb[b]) mem[(int'(wr_addr) + b) % MEMB] = wr_data[8*b +: 8];
      end
    end
  end

  task automatic fill_mem();
    for (int a = 0; a < MEMB; a++) begin
      mem[a] = 8'(a) ^ 8'hE5;
      expm[a] = mem[a];
    end
  endtask

  // Applies one store and checks memory, beat count, done and busy.
  task automatic run_store(input int bw, input int vl, input int vs,
                           input bit men, input logic [MAX_VL-1:0] mk,
                           input bit stl, input int seed, input string tag,
                           input bit poke_start);
    int exp_beats = 0;
    int last_bw = -1;
    int wait_n = 0;
    bit ok_busy = 1'b1;
    bit ok_mem = 1'b1;
    stall_mode = stl;
    beats = 0;
    last_addr = -1;
    for (int i = 0; i < MAX_VL; i++) elem[i] = 32'h1111_1111 * (i + 1) ^ (32'(seed) << 24);
    for (int i = 0; i < vl; i++) begin
      if (i >= vs && (!men || mk[i])) begin
        for (int b = 0; b < 4; b++) expm[4*(bw+i) + b] = elem[i][8*b +: 8];
        if (((bw + i) >> 1) != last_bw) begin
          exp_beats++;
          last_bw = (bw + i) >> 1;
        end
      end
    end
    @(negedge clk);
    base_word = 30'(bw); elem_cnt = CNT_W'(vl); first_idx = CNT_W'(vs);
    mask_en = men; mask_i = mk;
    for (int i = 0; i < MAX_VL; i++) data_i[32*i +: 32] = elem[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (vs >= vl) begin
      chk(done == 1'b1, "R7", {tag, " done one cycle after start"}, done, 1);
      chk(busy == 1'b0, "R7", {tag, " never busy"}, busy, 0);
    end else begin
      while (!done && wait_n < 2000) begin
        if (!busy) ok_busy = 1'b0;
        if (poke_start && wait_n == 4) begin
          base_word = 30'd2; elem_cnt = CNT_W'(3); first_idx = '0;
          mask_en = 1'b0; data_i = '1; start = 1'b1;
        end else start = 1'b0;
        @(negedge clk);
        wait_n++;
      end
      start = 1'b0;
      chk(done == 1'b1, "R6", {tag, " done reached"}, done, 1);
      chk(ok_busy, "R8", {tag, " busy held until done"}, 0, 1);
    end
    chk(resume_idx == '0, "R6", {tag, " resume index cleared"}, resume_idx, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6", {tag, " done is a single pulse"}, done, 0);
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " no second store started"}, busy, 0);
    chk(beats == exp_beats, "R4", {tag, " beat count"}, beats, exp_beats);
    for (int i = 0; i < vl && i < MAX_VL; i++) begin
      logic [31:0] a, e;
      for (int b = 0; b < 4; b++) begin
        a[8*b +: 8] = mem[4*(bw+i) + b];
        e[8*b +: 8] = expm[4*(bw+i) + b];
      end
      if (i < vs)
        chk(a == e, "R1", {tag, " element below first index kept"}, a, e);
      else if (men)
        chk(a == e, "R2", {tag, " masked element word"}, a, e);
      else
        chk(a == e, "R10", {tag, " unmasked element word"}, a, e);
    end
    for (int x = 0; x < MEMB; x++) if (mem[x] != expm[x]) ok_mem = 1'b0;
    chk(ok_mem, "R3", {tag, " whole memory image and lane placement"}, 0, 1);
  endtask

  initial begin
    #(150000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    fill_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !wr_valid && resume_idx == '0, "R6", "reset state",
        {busy, done, wr_valid}, 0);

    // R1 R2: start index 1, odd elements enabled, base on 8-byte boundary.
    run_store(16, 4, 1, 1'b1, 16'b1010, 1'b0, 1, "odd_mask", 1'b0);
    // R3: base on upper lane, nonzero start, irregular mask, with stalls.
    run_store(33, 5, 2, 1'b1, 16'b10110, 1'b1, 2, "upper_base", 1'b0);
    // R1: every mask bit set, start index 3.
    run_store(4, 7, 3, 1'b1, 16'hFFFF, 1'b0, 3, "start_three", 1'b0);
    // R10: masking disabled, mask word zero, full length with stalls.
    run_store(40, 16, 0, 1'b0, 16'h0000, 1'b1, 4, "no_mask", 1'b0);
    // R4: everything masked off, no beats.
    run_store(20, 6, 0, 1'b1, 16'h0000, 1'b0, 5, "all_off", 1'b0);
    // R7: start index equal to and above length.
    run_store(8, 2, 2, 1'b1, 16'hFFFF, 1'b0, 6, "vs_eq_vl", 1'b0);
    run_store(8, 3, 5, 1'b0, 16'hFFFF, 1'b0, 7, "vs_gt_vl", 1'b0);
    // R8: second start during a stalled store is ignored.
    fill_mem();
    run_store(12, 16, 1, 1'b1, 16'hA5C3, 1'b1, 8, "restart_ignored", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule